// File: doc/BRIEF.md
# CPU Memory Map Address Decoder

This block sits between an 8-bit CPU and the memories of a small system with a 16-bit address space. For every access it works out which target owns the address and raises that target's select strobe, plus its write enable for a write. It also gives the target a local offset and returns the selected target's read byte to the CPU. The memory arrays and the I/O register file live outside the block. The exception is the 127-byte high RAM, which is held inside and cleared on reset.

Most of the map is decoded from the top address nibble. The last page is split more finely. Two echo windows alias the work RAM banks. A write into the ROM half of the map is not stored anywhere; the block passes it to the bank controller as an address and data pair. External RAM and object attribute memory read as zero, and the block drops writes to them. Every video RAM write is announced on the following cycle by a one-cycle notify pulse that carries the written offset.

Top module: `cpu_addr_map`

## Requirements
- R1: A read with address 0x0000-0x3FFF asserts `rom0_sel`; `rom0_off` equals address bits [13:0] and `cpu_rdata` equals `rom0_rdata`.
- R2: A read with address 0x4000-0x7FFF asserts `romb_sel`; `romb_off` equals address bits [13:0] and `cpu_rdata` equals `romb_rdata`.
- R3: An access to 0x8000-0x9FFF asserts `vram_sel` (and `vram_we` when writing); `vram_off` equals address bits [12:0] and a read returns `vram_rdata`.
- R4: One cycle after a video RAM write, `vram_notify` is high for exactly one cycle and `vram_notify_off` holds the offset that was written.
- R5: Reads in 0xA000-0xBFFF and 0xFE00-0xFEFF return 0x00. Writes there assert no select, no write enable and no mapper write.
- R6: An access to 0xC000-0xCFFF or its echo 0xE000-0xEFFF selects work RAM bank 0 (`wram0_sel`, and `wram0_we` on writes), with `wram0_off` equal to address bits [11:0]. A read returns `wram0_rdata`.
- R7: An access to 0xD000-0xDFFF or its echo 0xF000-0xFDFF selects the switchable work RAM bank (`wram1_sel`, and `wram1_we` on writes), with `wram1_off` equal to address bits [11:0]. A read returns `wram1_rdata`.
- R8: An access to 0xFF00-0xFF7F selects the I/O port (`io_sel`, and `io_we` on writes), with `io_off` equal to address bits [6:0]. A read returns `io_rdata`.
- R9: Addresses 0xFF80-0xFFFE reach the internal high RAM. A write there is stored at the clock edge, and a later read of the same address returns the stored byte.
- R10: After reset every high RAM byte reads 0x00.
- R11: An access to 0xFFFF selects the interrupt-enable register (`ie_sel`, and `ie_we` on writes), and a read returns `ie_rdata`.
- R12: A write in 0x0000-0x7FFF asserts `mapper_we` with `mapper_addr` and `mapper_data` equal to the CPU address and data. No ROM select and no other write enable is raised.
- R13: At most one select output is high at a time. With neither `cpu_rd` nor `cpu_wr` asserted, all selects and write enables are low and `cpu_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data, also used by the external targets |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom0_sel | output | 1 | Fixed ROM read select |
| rom0_off | output | 14 | Fixed ROM offset |
| rom0_rdata | input | 8 | Fixed ROM read data |
| romb_sel | output | 1 | Banked ROM read select |
| romb_off | output | 14 | Banked ROM offset |
| romb_rdata | input | 8 | Banked ROM read data |
| vram_sel | output | 1 | Video RAM select |
| vram_we | output | 1 | Video RAM write enable |
| vram_off | output | 13 | Video RAM offset |
| vram_rdata | input | 8 | Video RAM read data |
| vram_notify | output | 1 | One-cycle pulse after a video RAM write |
| vram_notify_off | output | 13 | Offset of the announced video RAM write |
| wram0_sel | output | 1 | Work RAM bank 0 select |
| wram0_we | output | 1 | Work RAM bank 0 write enable |
| wram0_off | output | 12 | Work RAM bank 0 offset |
| wram0_rdata | input | 8 | Work RAM bank 0 read data |
| wram1_sel | output | 1 | Switchable work RAM bank select |
| wram1_we | output | 1 | Switchable work RAM bank write enable |
| wram1_off | output | 12 | Switchable work RAM bank offset |
| wram1_rdata | input | 8 | Switchable work RAM bank read data |
| io_sel | output | 1 | I/O port select |
| io_we | output | 1 | I/O port write enable |
| io_off | output | 7 | I/O register offset |
| io_rdata | input | 8 | I/O port read data |
| ie_sel | output | 1 | Interrupt-enable register select |
| ie_we | output | 1 | Interrupt-enable register write enable |
| ie_rdata | input | 8 | Interrupt-enable register read data |
| mapper_we | output | 1 | Write strobe to the bank controller |
| mapper_addr | output | 16 | Address forwarded to the bank controller |
| mapper_data | output | 8 | Data forwarded to the bank controller |

## Verification
Selects, write enables, offsets, mapper forwarding and read data are combinational. The bench drives each address on a falling edge and checks these outputs 1 ns later, in the same cycle. A high RAM write is stored at the next rising edge, so its read-back is checked on a later cycle. The video RAM notify pulse is registered: the bench checks that it is high in the cycle after the write cycle and low again one cycle after that. Every one of the 65536 addresses is swept as a read, and every fifth address as a write, against a region model in the bench built from address comparisons.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int ROM_OFF_W  = 14;
    localparam int VRAM_OFF_W = 13;
    localparam int WRAM_OFF_W = 12;
    localparam int IO_OFF_W   = 7;
    localparam int HRAM_DEPTH = 127;
    localparam int HRAM_AW    = $clog2(HRAM_DEPTH);

    localparam logic [ADDR_W-1:0] BASE_OAM  = 16'hFE00;
    localparam logic [ADDR_W-1:0] BASE_IO   = 16'hFF00;
    localparam logic [ADDR_W-1:0] BASE_HRAM = 16'hFF80;
    localparam logic [ADDR_W-1:0] ADDR_IE   = 16'hFFFF;

    typedef enum logic [3:0] {
        T_ROM0, T_ROMB, T_VRAM, T_XRAM, T_WRAM0,
        T_WRAM1, T_OAM, T_IO, T_HRAM, T_IE
    } tgt_e;

    typedef struct packed {
        logic rom0;
        logic romb;
        logic vram;
        logic wram0;
        logic wram1;
        logic io;
        logic hram;
        logic ie;
    } strobe_t;

    function automatic tgt_e classify(input logic [ADDR_W-1:0] a);
        tgt_e t;
        unique case (a[15:12])
            4'h0, 4'h1, 4'h2, 4'h3: t = T_ROM0;
            4'h4, 4'h5, 4'h6, 4'h7: t = T_ROMB;
            4'h8, 4'h9:             t = T_VRAM;
            4'hA, 4'hB:             t = T_XRAM;
            4'hC, 4'hE:             t = T_WRAM0;
            4'hD:                   t = T_WRAM1;
            default: begin
                if (a < BASE_OAM)       t = T_WRAM1;
                else if (a < BASE_IO)   t = T_OAM;
                else if (a < BASE_HRAM) t = T_IO;
                else if (a < ADDR_IE)   t = T_HRAM;
                else                    t = T_IE;
            end
        endcase
        return t;
    endfunction
endpackage

// File: rtl/map_decode.sv
module map_decode
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output tgt_e              tgt,
    output strobe_t           sel,
    output strobe_t           we,
    output logic              mapper_we
);
    always_comb begin
        tgt       = classify(addr);
        sel       = '0;
        we        = '0;
        mapper_we = 1'b0;
        unique case (tgt)
            T_ROM0:  begin sel.rom0 = rd; mapper_we = wr; end
            T_ROMB:  begin sel.romb = rd; mapper_we = wr; end
            T_VRAM:  begin sel.vram  = rd | wr; we.vram  = wr; end
            T_WRAM0: begin sel.wram0 = rd | wr; we.wram0 = wr; end
            T_WRAM1: begin sel.wram1 = rd | wr; we.wram1 = wr; end
            T_IO:    begin sel.io    = rd | wr; we.io    = wr; end
            T_HRAM:  begin sel.hram  = rd | wr; we.hram  = wr; end
            T_IE:    begin sel.ie    = rd | wr; we.ie    = wr; end
            default: ;
        endcase
    end
endmodule

// File: rtl/hram_store.sv
module hram_store
    import memmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [HRAM_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] mem [0:HRAM_DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HRAM_DEPTH; i++) mem[i] <= '0;
        end else if (we && (int'(addr) < HRAM_DEPTH)) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = (int'(addr) < HRAM_DEPTH) ? mem[addr] : '0;

    assert_hram_store_R9: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/read_mux.sv
module read_mux
    import memmap_pkg::*;
(
    input  logic              rd,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] rom0_d,
    input  logic [DATA_W-1:0] romb_d,
    input  logic [DATA_W-1:0] vram_d,
    input  logic [DATA_W-1:0] wram0_d,
    input  logic [DATA_W-1:0] wram1_d,
    input  logic [DATA_W-1:0] io_d,
    input  logic [DATA_W-1:0] hram_d,
    input  logic [DATA_W-1:0] ie_d,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (tgt)
                T_ROM0:  rdata = rom0_d;
                T_ROMB:  rdata = romb_d;
                T_VRAM:  rdata = vram_d;
                T_WRAM0: rdata = wram0_d;
                T_WRAM1: rdata = wram1_d;
                T_IO:    rdata = io_d;
                T_HRAM:  rdata = hram_d;
                T_IE:    rdata = ie_d;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cpu_addr_map.sv
module cpu_addr_map
    import memmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  rom0_sel,
    output logic [ROM_OFF_W-1:0]  rom0_off,
    input  logic [DATA_W-1:0]     rom0_rdata,
    output logic                  romb_sel,
    output logic [ROM_OFF_W-1:0]  romb_off,
    input  logic [DATA_W-1:0]     romb_rdata,
    output logic                  vram_sel,
    output logic                  vram_we,
    output logic [VRAM_OFF_W-1:0] vram_off,
    input  logic [DATA_W-1:0]     vram_rdata,
    output logic                  vram_notify,
    output logic [VRAM_OFF_W-1:0] vram_notify_off,
    output logic                  wram0_sel,
    output logic                  wram0_we,
    output logic [WRAM_OFF_W-1:0] wram0_off,
    input  logic [DATA_W-1:0]     wram0_rdata,
    output logic                  wram1_sel,
    output logic                  wram1_we,
    output logic [WRAM_OFF_W-1:0] wram1_off,
    input  logic [DATA_W-1:0]     wram1_rdata,
    output logic                  io_sel,
    output logic                  io_we,
    output logic [IO_OFF_W-1:0]   io_off,
    input  logic [DATA_W-1:0]     io_rdata,
    output logic                  ie_sel,
    output logic                  ie_we,
    input  logic [DATA_W-1:0]     ie_rdata,
    output logic                  mapper_we,
    output logic [ADDR_W-1:0]     mapper_addr,
    output logic [DATA_W-1:0]     mapper_data
);
    tgt_e              tgt;
    strobe_t           sel, we;
    logic [DATA_W-1:0] hram_q;

    map_decode u_dec (
        .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
        .tgt(tgt), .sel(sel), .we(we), .mapper_we(mapper_we)
    );

    hram_store u_hram (
        .clk(clk), .rst(rst), .we(we.hram),
        .addr(cpu_addr[HRAM_AW-1:0]), .wdata(cpu_wdata), .rdata(hram_q)
    );

    read_mux u_mux (
        .rd(cpu_rd), .tgt(tgt),
        .rom0_d(rom0_rdata), .romb_d(romb_rdata), .vram_d(vram_rdata),
        .wram0_d(wram0_rdata), .wram1_d(wram1_rdata), .io_d(io_rdata),
        .hram_d(hram_q), .ie_d(ie_rdata), .rdata(cpu_rdata)
    );

    assign rom0_sel  = sel.rom0;
    assign romb_sel  = sel.romb;
    assign vram_sel  = sel.vram;
    assign wram0_sel = sel.wram0;
    assign wram1_sel = sel.wram1;
    assign io_sel    = sel.io;
    assign ie_sel    = sel.ie;
    assign vram_we   = we.vram;
    assign wram0_we  = we.wram0;
    assign wram1_we  = we.wram1;
    assign io_we     = we.io;
    assign ie_we     = we.ie;

    assign rom0_off  = cpu_addr[ROM_OFF_W-1:0];
    assign romb_off  = cpu_addr[ROM_OFF_W-1:0];
    assign vram_off  = cpu_addr[VRAM_OFF_W-1:0];
    assign wram0_off = cpu_addr[WRAM_OFF_W-1:0];
    assign wram1_off = cpu_addr[WRAM_OFF_W-1:0];
    assign io_off    = cpu_addr[IO_OFF_W-1:0];

    assign mapper_addr = cpu_addr;
    assign mapper_data = cpu_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            vram_notify     <= 1'b0;
            vram_notify_off <= '0;
        end else begin
            vram_notify <= we.vram;
            if (we.vram) vram_notify_off <= cpu_addr[VRAM_OFF_W-1:0];
        end
    end

    assert_one_select_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom0_sel, romb_sel, vram_sel, wram0_sel, wram1_sel, io_sel, ie_sel}));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd || cpu_wr) |-> (sel == '0 && we == '0 && !mapper_we && cpu_rdata == '0));

    assert_notify_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        vram_we |=> (vram_notify && vram_notify_off == $past(vram_off)));

    assert_mapper_only_R12: assert property (@(posedge clk) disable iff (rst)
        mapper_we |-> (!cpu_addr[15] && we == '0 && !rom0_sel && !romb_sel));

    assert_dead_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && (tgt == T_XRAM || tgt == T_OAM)) |-> (cpu_rdata == '0 && sel == '0));
endmodule

// File: tb/cpu_addr_map_test.sv
`timescale 1ns/100ps
module cpu_addr_map_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        rom0_sel, romb_sel, vram_sel, vram_we, vram_notify;
    logic [13:0] rom0_off, romb_off;
    logic [12:0] vram_off, vram_notify_off;
    logic        wram0_sel, wram0_we, wram1_sel, wram1_we;
    logic [11:0] wram0_off, wram1_off;
    logic        io_sel, io_we, ie_sel, ie_we, mapper_we;
    logic [6:0]  io_off;
    logic [15:0] mapper_addr;
    logic [7:0]  mapper_data;

    localparam logic [7:0] D_ROM0 = 8'hA1, D_ROMB = 8'hB2, D_VRAM = 8'hC3,
                           D_W0 = 8'hD4, D_W1 = 8'hE5, D_IO = 8'h96, D_IE = 8'h87;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu_addr_map uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rom0_sel(rom0_sel), .rom0_off(rom0_off), .rom0_rdata(D_ROM0),
        .romb_sel(romb_sel), .romb_off(romb_off), .romb_rdata(D_ROMB),
        .vram_sel(vram_sel), .vram_we(vram_we), .vram_off(vram_off), .vram_rdata(D_VRAM),
        .vram_notify(vram_notify), .vram_notify_off(vram_notify_off),
        .wram0_sel(wram0_sel), .wram0_we(wram0_we), .wram0_off(wram0_off), .wram0_rdata(D_W0),
        .wram1_sel(wram1_sel), .wram1_we(wram1_we), .wram1_off(wram1_off), .wram1_rdata(D_W1),
        .io_sel(io_sel), .io_we(io_we), .io_off(io_off), .io_rdata(D_IO),
        .ie_sel(ie_sel), .ie_we(ie_we), .ie_rdata(D_IE),
        .mapper_we(mapper_we), .mapper_addr(mapper_addr), .mapper_data(mapper_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=0x%0h exp=0x%0h addr=0x%04h", tag, act, exp, cpu_addr);
        end
    endtask

    // 0 rom0,1 romb,2 vram,3 xram,4 wram0,5 wram1,6 oam,7 io,8 hram,9 ie
    function automatic int region(input int a);
        if (a < 'h4000) return 0;
        if (a < 'h8000) return 1;
        if (a < 'hA000) return 2;
        if (a < 'hC000) return 3;
        if (a < 'hD000) return 4;
        if (a < 'hE000) return 5;
        if (a < 'hF000) return 4;
        if (a < 'hFE00) return 5;
        if (a < 'hFF00) return 6;
        if (a < 'hFF80) return 7;
        if (a < 'hFFFF) return 8;
        return 9;
    endfunction

    function automatic logic [6:0] sel_bits(input int r);
        case (r)
            0: return 7'b0000001;
            1: return 7'b0000010;
            2: return 7'b0000100;
            4: return 7'b0001000;
            5: return 7'b0010000;
            7: return 7'b0100000;
            9: return 7'b1000000;
            default: return 7'b0;
        endcase
    endfunction

    function automatic string rtag(input int r);
        case (r)
            0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R5";
            4: return "R6"; 5: return "R7"; 6: return "R5"; 7: return "R8";
            8: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic drive(input int a, input bit rd, input bit wr, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a[15:0]; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        #1;
    endtask

    logic [6:0] sv;
    logic [4:0] wv;

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        sv = {ie_sel, io_sel, wram1_sel, wram0_sel, vram_sel, romb_sel, rom0_sel};
        check(sv == 0 && !mapper_we && cpu_rdata == 0 && !vram_notify, "R13 idle after reset",
              {sv, cpu_rdata}, 0);

        // read sweep of the whole map; high RAM is fresh from reset (R10)
        for (int a = 0; a < 65536; a++) begin
            int r;
            logic [7:0] ed;
            bit offok;
            r = region(a);
            drive(a, 1, 0, 8'h00);
            sv = {ie_sel, io_sel, wram1_sel, wram0_sel, vram_sel, romb_sel, rom0_sel};
            case (r)
                0: ed = D_ROM0; 1: ed = D_ROMB; 2: ed = D_VRAM; 4: ed = D_W0;
                5: ed = D_W1; 7: ed = D_IO; 9: ed = D_IE; default: ed = 8'h00;
            endcase
            case (r)
                0: offok = rom0_off == a[13:0];
                1: offok = romb_off == a[13:0];
                2: offok = vram_off == a[12:0];
                4: offok = wram0_off == a[11:0];
                5: offok = wram1_off == a[11:0];
                7: offok = io_off == a[6:0];
                default: offok = 1;
            endcase
            check(sv == sel_bits(r) && !mapper_we, {rtag(r), " R13 read select"},
                  sv, sel_bits(r));
            check(cpu_rdata == ed, {rtag(r), " read data"}, cpu_rdata, ed);
            check(offok, {rtag(r), " offset"}, a, a);
        end

        // write sweep
        for (int a = 0; a < 65536 + 5; a += 5) begin
            int aa, r;
            logic [7:0] d;
            logic [4:0] ew;
            aa = (a > 65535) ? 65535 : a;
            r = region(aa);
            d = aa[7:0] ^ 8'h5A;
            drive(aa, 0, 1, d);
            sv = {ie_sel, io_sel, wram1_sel, wram0_sel, vram_sel, romb_sel, rom0_sel};
            wv = {ie_we, io_we, wram1_we, wram0_we, vram_we};
            ew = {sel_bits(r)[6:2]};
            if (r <= 1) begin
                check(mapper_we && mapper_addr == aa[15:0] && mapper_data == d && wv == 0 && sv == 0,
                      "R12 rom write forwarded", {mapper_we, mapper_addr, mapper_data}, {1'b1, aa[15:0], d});
            end else begin
                check(!mapper_we && wv == ew && sv == {ew, 2'b00}, {rtag(r), " R5 write strobes"},
                      {sv, wv}, {ew, 2'b00, ew});
            end
        end

        // notify pulse
        drive('h9ABC, 0, 1, 8'h33);
        drive('h0000, 0, 0, 8'h00);
        check(vram_notify && vram_notify_off == 13'h1ABC, "R4 notify pulse",
              {vram_notify, vram_notify_off}, {1'b1, 13'h1ABC});
        drive('h0000, 0, 0, 8'h00);
        check(!vram_notify, "R4 notify one cycle", vram_notify, 0);
        drive('h8001, 1, 0, 8'h00);
        drive('h8001, 1, 0, 8'h00);
        check(!vram_notify, "R4 no notify on read", vram_notify, 0);

        // high RAM store and read back
        for (int i = 0; i < 127; i++) drive('hFF80 + i, 0, 1, 8'((i * 3) + 7));
        drive('hFFFF, 0, 1, 8'hEE);
        drive('hFF7F, 0, 1, 8'hEE);
        for (int i = 0; i < 127; i++) begin
            logic [7:0] e;
            e = 8'((i * 3) + 7);
            drive('hFF80 + i, 1, 0, 8'h00);
            check(cpu_rdata == e, "R9 high RAM readback", cpu_rdata, e);
        end
        drive('hFFFE, 0, 0, 8'h00);
        check(cpu_rdata == 0, "R13 idle rdata zero", cpu_rdata, 0);

        // reset clears high RAM again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 127; i += 9) begin
            drive('hFF80 + i, 1, 0, 8'h00);
            check(cpu_rdata == 0, "R10 cleared by reset", cpu_rdata, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule